// File: doc/BRIEF.md
# Flow-Controlled UART Transmitter with Break

This block turns words from a transmit stream into asynchronous serial frames on a single TXD line. A baud tick, one clock wide and produced outside the block, marks every bit boundary. Each frame holds one start bit, eight, nine or ten character bits, and one or two stop bits. When parity is on, the last character bit is the parity bit. The data bits go out LSB first or MSB first, and the whole line can be inverted.

Words arrive over a valid/ready interface into a holding register with one entry. `in_ready` is high exactly when that register is empty, and a word is taken on any clock where `in_valid` and `in_ready` are both high. The producer has to keep `in_valid` and the word steady until that happens. A word carrying the special flag is sent as a break when its data field is zero, and as an idle character otherwise. A pulse on `brk_req` queues a break, which goes out at the next character boundary.

Handshaking follows the usual modem lines. When CTS gating is on, a character can only start while the active-low CTS input is asserted. Once a character has started, CTS no longer affects it. When RTS framing is on, RTS asserts one bit time before the first start bit of a burst and releases one bit time after its last stop bit. The polarity of RTS can be chosen.

Top module: `flowtx_core`

## Requirements
- R1: After reset, txd is 1 (mark), rts is at its inactive level (1 with cfg_rts_high=0), and tx_done, tdre and in_ready are all 1.
- R2: A frame is one start bit at 0, then N character bits, then one stop bit (or two with cfg_two_stop=1) at 1. cfg_len code 0 gives N=8, code 1 gives N=9, codes 2 and 3 give N=10. The default order is LSB first. Back-to-back frames follow each other with no gap.
- R3: With cfg_par_en=1, the first N-1 character bits carry data[N-2:0] and bit N is parity over those bits. Parity is even when cfg_par_odd=0 and odd when it is 1.
- R4: cfg_msb_first=1 sends the data bits from the highest index down, with parity still last. cfg_tx_inv=1 inverts the whole line, so idle reads 0.
- R5: With cfg_cts_en=1 and cts_n=1, a word that is waiting is not started. txd stays at mark and tx_done and tdre stay 0. The frame starts at a tick after cts_n goes to 0.
- R6: A change of cts_n while a frame is on the line leaves that frame unchanged.
- R7: With cfg_cts_idle=0, CTS is checked again before every character, so a queued word waits while cts_n=1. With cfg_cts_idle=1, a word queued back-to-back goes out even if cts_n has risen.
- R8: With cfg_rts_en=1, RTS becomes active exactly one bit time (8 clocks in the bench) before the start edge of a burst. It becomes inactive one bit time after the end of the last stop bit.
- R9: RTS is active high when cfg_rts_high=1 and active low when it is 0. With cfg_rts_en=0, RTS stays inactive.
- R10: A break drives 0 for 10 + L + S bit times, where L is 0, 1 or 2 for N = 8, 9 or 10 and S is 1 when two stop bits are selected. cfg_brk_long=1 adds 3 bit times.
- R11: A brk_req pulse during a frame sends the break right after that frame's last stop bit. A special word with data 0 sends a break. A special word with nonzero data holds the line at mark for one full frame length.
- R12: Acceptance of a word (in_valid and in_ready) drives in_ready and tdre low on the next cycle. tx_done is 1 only when nothing is on the line, no RTS trailer is running, and neither a word nor a break is pending.
- R13: txd changes only on the clock edge that follows a cycle where baud_tick was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-clock pulse at each bit boundary |
| in_valid | input | 1 | Stream word valid |
| in_ready | output | 1 | Holding register empty; a word is taken when valid and ready are both high |
| in_data | input | 10 | Character bits, right-aligned |
| in_special | input | 1 | Word is a special character (break if data 0, idle otherwise) |
| brk_req | input | 1 | Pulse that queues a break for the next boundary |
| cts_n | input | 1 | Clear-to-send, active low, asynchronous |
| cfg_len | input | 2 | Character length code: 0=8, 1=9, 2 or 3=10 bits |
| cfg_par_en | input | 1 | Parity enable |
| cfg_par_odd | input | 1 | Odd parity when 1 |
| cfg_two_stop | input | 1 | Two stop bits when 1 |
| cfg_msb_first | input | 1 | Data MSB first when 1 |
| cfg_tx_inv | input | 1 | Invert the txd line |
| cfg_cts_en | input | 1 | Gate characters on CTS |
| cfg_cts_idle | input | 1 | Check CTS only when starting from idle |
| cfg_rts_en | input | 1 | Frame RTS around bursts |
| cfg_rts_high | input | 1 | RTS active high when 1 |
| cfg_brk_long | input | 1 | Break 3 bit times longer |
| txd | output | 1 | Serial output |
| rts | output | 1 | Request-to-send |
| tx_done | output | 1 | Transmission complete |
| tdre | output | 1 | Holding register empty |

## Verification
A corrupted bit counter or shift register appears on txd within the same frame, as a wrong bit or a frame of the wrong length. The bench catches this by comparing every bit time against a frame model built from the format settings. Sequencer state errors show up as RTS edges moving off their one-bit-time marks, or as a queued word starting while CTS is deasserted, which is seen within one bit time. A stuck holding-register flag freezes in_ready, tdre and tx_done on the next clock.

// File: rtl/ftx_pkg.sv
package ftx_pkg;
  localparam int CHAR_MAX = 10;
  localparam int FRAME_W  = 16;
  localparam int LEN_W    = $clog2(FRAME_W + 1);

  typedef struct packed {
    logic [FRAME_W-1:0] bits;
    logic [LEN_W-1:0]   len;
  } frame_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_SEND  = 2'd2,
    ST_TRAIL = 2'd3
  } seq_e;
endpackage

// File: rtl/ftx_sync.sv
module ftx_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  generate
    if (STAGES == 0) begin : g_pass
      assign q = d;
    end else begin : g_chain
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else if (STAGES == 1) chain[0] <= d;
        else chain <= {chain[STAGES-2:0], d};
      end
      assign q = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/ftx_hold.sv
module ftx_hold #(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          in_special,
  input  logic          take,
  output logic          full,
  output logic [DW-1:0] hold_data,
  output logic          hold_special
);
  assign in_ready = !full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full         <= 1'b0;
      hold_data    <= '0;
      hold_special <= 1'b0;
    end else if (in_valid && !full) begin
      full         <= 1'b1;
      hold_data    <= in_data;
      hold_special <= in_special;
    end else if (take) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/ftx_framer.sv
module ftx_framer
  import ftx_pkg::*;
(
  input  logic [CHAR_MAX-1:0] data,
  input  logic                special,
  input  logic                force_brk,
  input  logic [1:0]          cfg_len,
  input  logic                cfg_par_en,
  input  logic                cfg_par_odd,
  input  logic                cfg_two_stop,
  input  logic                cfg_msb_first,
  input  logic                cfg_brk_long,
  output frame_t              frame
);
  logic [3:0]       nbits;
  logic [3:0]       ndata;
  logic [LEN_W-1:0] flen;
  logic             par;
  logic             send_brk;
  logic             send_idle;

  always_comb begin
    case (cfg_len)
      2'd0:    nbits = 4'd8;
      2'd1:    nbits = 4'd9;
      default: nbits = 4'd10;
    endcase
    ndata     = nbits - {3'd0, cfg_par_en};
    flen      = LEN_W'(nbits) + LEN_W'(cfg_two_stop) + LEN_W'(2);
    send_brk  = force_brk | (special & (data == '0));
    send_idle = !force_brk & special & (data != '0);

    par        = cfg_par_odd;
    frame.bits = '1;
    frame.bits[0] = 1'b0;
    for (int i = 0; i < CHAR_MAX; i++) begin
      if (i < int'(ndata)) begin
        par = par ^ data[i];
        frame.bits[i+1] = cfg_msb_first ? data[int'(ndata) - 1 - i] : data[i];
      end
    end
    if (cfg_par_en) frame.bits[nbits] = par;
    frame.len = flen;

    if (send_brk) begin
      frame.bits = '0;
      frame.len  = flen + (cfg_brk_long ? LEN_W'(3) : LEN_W'(0));
    end else if (send_idle) begin
      frame.bits = '1;
    end
  end
endmodule

// File: rtl/ftx_seq.sv
module ftx_seq
  import ftx_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   tick,
  input  logic   hold_full,
  input  frame_t frame,
  input  logic   brk_req,
  input  logic   cts_ok,
  input  logic   cfg_cts_en,
  input  logic   cfg_cts_idle,
  input  logic   cfg_rts_en,
  output logic   line,
  output logic   busy,
  output logic   take,
  output logic   brk_pend
);
  seq_e               st;
  logic [FRAME_W-1:0] sh;
  logic [LEN_W-1:0]   cnt;
  logic               go_idle;
  logic               go_b2b;
  logic               last_bit;
  logic               load;

  always_comb begin
    go_idle  = brk_pend | (hold_full & (!cfg_cts_en | cts_ok));
    go_b2b   = brk_pend | (hold_full & (!cfg_cts_en | cfg_cts_idle | cts_ok));
    last_bit = (cnt == LEN_W'(1));
    load     = tick & (((st == ST_IDLE) & go_idle & !cfg_rts_en) |
                       (st == ST_LEAD) |
                       ((st == ST_SEND) & last_bit & go_b2b));
    take     = load & !brk_pend;
    line     = (st == ST_SEND) ? sh[0] : 1'b1;
    busy     = (st != ST_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      sh       <= '1;
      cnt      <= '0;
      brk_pend <= 1'b0;
    end else begin
      brk_pend <= brk_req | (brk_pend & !load);
      if (load) begin
        st  <= ST_SEND;
        sh  <= frame.bits;
        cnt <= frame.len;
      end else if (tick) begin
        case (st)
          ST_IDLE:  if (go_idle) st <= ST_LEAD;
          ST_SEND: begin
            if (last_bit) st <= cfg_rts_en ? ST_TRAIL : ST_IDLE;
            sh  <= {1'b1, sh[FRAME_W-1:1]};
            cnt <= cnt - LEN_W'(1);
          end
          ST_TRAIL: st <= ST_IDLE;
          default:  st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/flowtx_core.sv
module flowtx_core
  import ftx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         baud_tick,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [ftx_pkg::CHAR_MAX-1:0] in_data,
  input  logic                         in_special,
  input  logic                         brk_req,
  input  logic                         cts_n,
  input  logic [1:0]                   cfg_len,
  input  logic                         cfg_par_en,
  input  logic                         cfg_par_odd,
  input  logic                         cfg_two_stop,
  input  logic                         cfg_msb_first,
  input  logic                         cfg_tx_inv,
  input  logic                         cfg_cts_en,
  input  logic                         cfg_cts_idle,
  input  logic                         cfg_rts_en,
  input  logic                         cfg_rts_high,
  input  logic                         cfg_brk_long,
  output logic                         txd,
  output logic                         rts,
  output logic                         tx_done,
  output logic                         tdre
);
  logic                cts_n_s;
  logic                hold_full;
  logic [CHAR_MAX-1:0] hold_data;
  logic                hold_special;
  logic                take;
  logic                brk_pend;
  logic                line;
  logic                busy;
  frame_t              frame;

  ftx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cts_sync (
    .clk(clk), .rst_n(rst_n), .d(cts_n), .q(cts_n_s)
  );

  ftx_hold #(.DW(CHAR_MAX)) u_hold (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_special(in_special), .take(take),
    .full(hold_full), .hold_data(hold_data), .hold_special(hold_special)
  );

  ftx_framer u_framer (
    .data(hold_data), .special(hold_special), .force_brk(brk_pend),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_two_stop(cfg_two_stop), .cfg_msb_first(cfg_msb_first),
    .cfg_brk_long(cfg_brk_long), .frame(frame)
  );

  ftx_seq u_seq (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .hold_full(hold_full),
    .frame(frame), .brk_req(brk_req), .cts_ok(!cts_n_s),
    .cfg_cts_en(cfg_cts_en), .cfg_cts_idle(cfg_cts_idle),
    .cfg_rts_en(cfg_rts_en), .line(line), .busy(busy), .take(take),
    .brk_pend(brk_pend)
  );

  assign txd     = line ^ cfg_tx_inv;
  assign rts     = (cfg_rts_en & busy) ? cfg_rts_high : !cfg_rts_high;
  assign tx_done = !busy & !hold_full & !brk_pend;
  assign tdre    = !hold_full;
endmodule

// File: rtl/flowtx_chk.sv
module flowtx_chk (
  input logic clk,
  input logic rst_n,
  input logic baud_tick,
  input logic in_valid,
  input logic in_ready,
  input logic cfg_tx_inv,
  input logic cfg_rts_en,
  input logic cfg_rts_high,
  input logic txd,
  input logic rts,
  input logic tx_done,
  input logic tdre
);
  // R13
  txd_tick_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(baud_tick) && $stable(cfg_tx_inv)) |-> $stable(txd));

  // R12
  accept_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R12
  done_means_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> (txd == !cfg_tx_inv));

  // R9
  rts_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rts_en |-> (rts == !cfg_rts_high));

  // R12
  done_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> tdre);
endmodule

bind flowtx_core flowtx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .in_valid(in_valid),
  .in_ready(in_ready), .cfg_tx_inv(cfg_tx_inv), .cfg_rts_en(cfg_rts_en),
  .cfg_rts_high(cfg_rts_high), .txd(txd), .rts(rts), .tx_done(tx_done),
  .tdre(tdre)
);

// File: tb/sim_flowtx_core.sv
`timescale 1ns/1ps
module sim_flowtx_core;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic baud_tick = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [9:0] in_data = '0;
  logic in_special = 1'b0;
  logic brk_req = 1'b0;
  logic cts_n = 1'b0;
  logic [1:0] cfg_len = 2'd0;
  logic cfg_par_en = 0, cfg_par_odd = 0, cfg_two_stop = 0, cfg_msb_first = 0;
  logic cfg_tx_inv = 0, cfg_cts_en = 0, cfg_cts_idle = 0, cfg_rts_en = 0;
  logic cfg_rts_high = 0, cfg_brk_long = 0;
  logic txd, rts, tx_done, tdre;

  int vectors = 0;
  int fails = 0;
  int cyc = 0;
  int tick_cyc = -1;
  bit edge_on_tick;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (baud_tick) tick_cyc <= cyc + 1;
  end

  initial begin
    forever begin
      repeat (7) @(negedge clk);
      baud_tick = 1'b1;
      @(negedge clk);
      baud_tick = 1'b0;
    end
  end

  flowtx_core u0 (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .in_special(in_special),
    .brk_req(brk_req), .cts_n(cts_n), .cfg_len(cfg_len),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_two_stop(cfg_two_stop), .cfg_msb_first(cfg_msb_first),
    .cfg_tx_inv(cfg_tx_inv), .cfg_cts_en(cfg_cts_en),
    .cfg_cts_idle(cfg_cts_idle), .cfg_rts_en(cfg_rts_en),
    .cfg_rts_high(cfg_rts_high), .cfg_brk_long(cfg_brk_long),
    .txd(txd), .rts(rts), .tx_done(tx_done), .tdre(tdre)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mkf(input logic [9:0] d, input int nch,
                                      input bit par, input bit odd, input bit msb);
    logic [63:0] v = '1;
    int dn = nch - (par ? 1 : 0);
    bit p = odd;
    v[0] = 1'b0;
    for (int i = 0; i < dn; i++) begin
      p ^= d[i];
      v[1+i] = msb ? d[dn-1-i] : d[i];
    end
    if (par) v[nch] = p;
    return v;
  endfunction

  function automatic logic [63:0] cat(input logic [63:0] a, input int la, input logic [63:0] b);
    return (a & ((64'd1 << la) - 64'd1)) | (b << la);
  endfunction

  function automatic logic [63:0] mask(input logic [63:0] v, input int n);
    return v & ((64'd1 << n) - 64'd1);
  endfunction

  function automatic logic [63:0] brkv(input int n);
    return ~((64'd1 << n) - 64'd1);
  endfunction

  task automatic push(input logic [9:0] d, input logic sp);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_special = sp;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pulse_brk();
    @(negedge clk); brk_req = 1'b1;
    @(negedge clk); brk_req = 1'b0;
  endtask

  task automatic capture(input int n, output logic [63:0] v);
    v = '0;
    @(negedge clk);
    while ((txd ^ cfg_tx_inv) !== 1'b0) @(negedge clk);
    edge_on_tick = (tick_cyc == cyc);
    repeat (4) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      if (k > 0) repeat (8) @(negedge clk);
      v[k] = txd ^ cfg_tx_inv;
    end
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!tx_done) @(negedge clk);
    repeat (20) @(negedge clk);
  endtask

  task automatic defaults();
    cfg_len = 2'd0; cfg_par_en = 0; cfg_par_odd = 0; cfg_two_stop = 0;
    cfg_msb_first = 0; cfg_tx_inv = 0; cfg_cts_en = 0; cfg_cts_idle = 0;
    cfg_rts_en = 0; cfg_rts_high = 0; cfg_brk_long = 0; cts_n = 0;
  endtask

  task automatic t_reset();
    // R1: mark line, RTS inactive, done and empty flags high
    chk("R1 reset outputs", {60'd0, txd, rts, tx_done, tdre},
        {60'd0, 1'b1, 1'b1, 1'b1, 1'b1});
    chk("R1 reset in_ready", {63'd0, in_ready}, 64'd1);
  endtask

  task automatic t_basic();
    logic [63:0] v;
    defaults();
    fork
      push(10'h0A5, 1'b0);
      capture(10, v);
    join
    chk("R2 8N1 LSB-first frame", v, mask(mkf(10'h0A5, 8, 0, 0, 0), 10));
    // R13: start edge lands on a tick edge
    chk("R13 start edge on tick", {63'd0, edge_on_tick}, 64'd1);
    wait_idle();
  endtask

  task automatic t_parity();
    logic [63:0] v;
    logic [63:0] e;
    defaults();
    cfg_len = 2'd1; cfg_par_en = 1; cfg_par_odd = 1; cfg_two_stop = 1;
    e = cat(mkf(10'h03C, 9, 1, 1, 0), 12, mkf(10'h081, 9, 1, 1, 0));
    fork
      begin push(10'h03C, 0); push(10'h081, 0); end
      capture(24, v);
    join
    chk("R3 R2 odd parity, two stops, back-to-back", v, mask(e, 24));
    wait_idle();
    cfg_par_odd = 0; cfg_two_stop = 0;
    fork
      push(10'h0B3, 0);
      capture(11, v);
    join
    chk("R3 even parity 9-bit", v, mask(mkf(10'h0B3, 9, 1, 0, 0), 11));
    wait_idle();
  endtask

  task automatic t_msb_inv();
    logic [63:0] v;
    defaults();
    cfg_len = 2'd2; cfg_msb_first = 1; cfg_tx_inv = 1;
    @(negedge clk);
    // R4: inverted idle line is 0
    chk("R4 inverted idle level", {63'd0, txd}, 64'd0);
    fork
      push(10'h2C5, 0);
      capture(12, v);
    join
    chk("R4 MSB-first 10-bit inverted", v, mask(mkf(10'h2C5, 10, 0, 0, 1), 12));
    wait_idle();
    cfg_tx_inv = 0;
  endtask

  task automatic t_cts_block();
    logic [63:0] v;
    defaults();
    cfg_cts_en = 1; cts_n = 1;
    push(10'h055, 0);
    repeat (80) @(negedge clk);
    chk("R5 line held at mark while CTS off", {63'd0, txd}, 64'd1);
    chk("R12 done and tdre low with word waiting", {62'd0, tx_done, tdre}, 64'd0);
    fork
      begin @(negedge clk); cts_n = 0; end
      capture(10, v);
    join
    chk("R5 frame after CTS asserts", v, mask(mkf(10'h055, 8, 0, 0, 0), 10));
    wait_idle();
  endtask

  task automatic t_cts_mid(input bit idle_mode);
    logic [63:0] v;
    defaults();
    cfg_cts_en = 1; cfg_cts_idle = idle_mode; cts_n = 0;
    fork
      begin push(10'h0C3, 0); push(10'h01E, 0); end
      capture(idle_mode ? 20 : 10, v);
      begin
        @(negedge clk);
        while (txd !== 1'b0) @(negedge clk);
        repeat (20) @(negedge clk);
        cts_n = 1;
      end
    join
    if (idle_mode) begin
      chk("R7 idle-only CTS: back-to-back word still sent", v,
          mask(cat(mkf(10'h0C3, 8, 0, 0, 0), 10, mkf(10'h01E, 8, 0, 0, 0)), 20));
    end else begin
      chk("R6 frame unaffected by CTS drop", v, mask(mkf(10'h0C3, 8, 0, 0, 0), 10));
      repeat (40) @(negedge clk);
      chk("R7 per-char CTS: next word held", {62'd0, txd, tdre}, {62'd0, 1'b1, 1'b0});
      fork
        begin @(negedge clk); cts_n = 0; end
        capture(10, v);
      join
      chk("R7 held word sent after CTS returns", v, mask(mkf(10'h01E, 8, 0, 0, 0), 10));
    end
    wait_idle();
    cts_n = 0;
  endtask

  task automatic t_rts(input bit hi);
    int tr, ts, tf;
    logic act;
    defaults();
    cfg_rts_en = 1; cfg_rts_high = hi;
    act = hi;
    @(negedge clk);
    chk("R9 RTS inactive level before burst", {63'd0, rts}, {63'd0, !act});
    tr = 0; ts = 0; tf = 0;
    fork
      push(10'h0F0, 0);
      begin
        @(negedge clk);
        while (rts !== act) @(negedge clk);
        tr = cyc;
        while (txd !== 1'b0) @(negedge clk);
        ts = cyc;
        while (rts === act) @(negedge clk);
        tf = cyc;
      end
    join
    chk("R8 RTS leads start by one bit", 64'(ts - tr), 64'd8);
    chk("R8 R9 RTS releases one bit after stop", 64'(tf - ts), 64'd88);
    wait_idle();
  endtask

  task automatic t_break();
    logic [63:0] v;
    defaults();
    fork
      pulse_brk();
      capture(11, v);
    join
    chk("R10 break 8N1 normal length", v, mask(brkv(10), 11));
    wait_idle();
    cfg_len = 2'd2; cfg_two_stop = 1; cfg_brk_long = 1;
    fork
      pulse_brk();
      capture(17, v);
    join
    chk("R10 break 10-bit two-stop long length", v, mask(brkv(16), 17));
    wait_idle();
  endtask

  task automatic t_brk_boundary();
    logic [63:0] v;
    defaults();
    fork
      push(10'h066, 0);
      capture(21, v);
      begin
        @(negedge clk);
        while (txd !== 1'b0) @(negedge clk);
        repeat (10) @(negedge clk);
        pulse_brk();
      end
    join
    chk("R11 queued break follows frame", v,
        mask(cat(mkf(10'h066, 8, 0, 0, 0), 10, brkv(10)), 21));
    wait_idle();
  endtask

  task automatic t_special();
    logic [63:0] v;
    defaults();
    fork
      push(10'h000, 1);
      capture(11, v);
    join
    chk("R11 special zero word is a break", v, mask(brkv(10), 11));
    wait_idle();
    fork
      begin push(10'h011, 0); push(10'h001, 1); push(10'h0E7, 0); end
      capture(30, v);
    join
    chk("R11 special nonzero word is an idle character", v,
        mask(cat(cat(mkf(10'h011, 8, 0, 0, 0), 10, 64'hFFFF_FFFF_FFFF_FFFF),
                 20, mkf(10'h0E7, 8, 0, 0, 0)), 30));
    wait_idle();
  endtask

  initial begin
    defaults();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    fork
      begin
        t_reset();
        t_basic();
        t_parity();
        t_msb_inv();
        t_cts_block();
        t_cts_mid(1'b0);
        t_cts_mid(1'b1);
        t_rts(1'b1);
        t_rts(1'b0);
        t_break();
        t_brk_boundary();
        t_special();
      end
      begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R12 watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule